// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a 16-bit down-counting timer that serves either as a periodic general-purpose timer or as a watchdog. A slow tick of 32.768 kHz, arriving as a one-cycle pulse on the fast system clock, is divided by 1, 16 or 256. Each divided step lowers the count by one. A step that finds the count already at zero is a timeout: the count reloads from the load register. In normal mode a timeout raises a sticky interrupt. In watchdog mode it raises either a one-cycle reset request or that interrupt.

Software reaches the block through a small register port with four word registers. A write of any value to the clear register restarts the period at once and drops the interrupt. Setting the watchdog bit locks the load and control registers. The lock holds until power-on reset. A system reset does not disturb the watchdog once the lock is in place. Counting pauses while a debugger holds the core. It may also be set to pause during power-down.

Top module: `wdt_timer`

## Requirements
- R1: After power-on reset, offset 0x00 (load) and offset 0x04 (count value) both read 0x03D7, offset 0x08 (control) reads 0x0000, offset 0x0C (clear) reads 0x0000, and both the interrupt and the reset request are low.
- R2: Control bits [3:2] select how many qualified ticks make one count step: 00 gives 1, 01 gives 16, 10 gives 256 and 11 also gives 256.
- R3: Each step lowers a non-zero count by one. A step at count 0 reloads the load value and is a timeout, so one period is load+1 steps.
- R4: A write of any data to offset 0x0C reloads the count from the load register in the next cycle, restarts the tick divider and clears the interrupt.
- R5: In normal mode, control bit 7 enables counting, and with it low the count holds. A timeout sets the interrupt, which stays high until a clear write.
- R6: Setting control bit 5 enters watchdog mode, which counts whatever bit 7 holds. On timeout, control bit 1 = 0 gives a reset request high for exactly one cycle, and bit 1 = 1 sets the sticky interrupt instead.
- R7: Once watchdog mode is set, writes to load and control are ignored until the next power-on reset, while clear writes still work.
- R8: A low system reset input restores the register, count and interrupt defaults in normal mode. In watchdog mode it leaves count, load and control unchanged.
- R9: While the debug-halt input is high, ticks are ignored and the count holds. Counting resumes when the input falls.
- R10: With control bit 0 set, ticks are ignored while the power-down input is high. With bit 0 clear, counting continues during power-down.
- R11: Writes to offset 0x04 have no effect: the count is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_n_i | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n_i | input | 1 | System reset, synchronous, active low |
| tick_i | input | 1 | One-cycle pulse per 32.768 kHz period |
| dbg_halt_i | input | 1 | Debugger holds the core |
| pwr_down_i | input | 1 | System is in power-down |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| rst_req_o | output | 1 | Watchdog reset request, one-cycle pulse |
| irq_o | output | 1 | Timeout interrupt, held until a clear write |

## Verification
A wrong count or a wrong divider phase shows as a count read back off by one or more after a known number of ticks. When it corrupts the timeout, it shows within one period as an interrupt or reset pulse one step early or late. A lock that fails to hold shows at once as changed load or control read-back after a write in watchdog mode. A system reset that leaks into the watchdog shows as the count jumping back to 0x03D7 on the very next cycle. A reset pulse that is too long shows in the cycle after its rise.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Register index taken from byte-address bits [3:2]
    typedef enum logic [1:0] {
        RSEL_LOAD  = 2'd0,
        RSEL_VALUE = 2'd1,
        RSEL_CTRL  = 2'd2,
        RSEL_CLEAR = 2'd3
    } rsel_e;

    // Control register bit positions
    localparam int unsigned CB_PD_STOP = 0;
    localparam int unsigned CB_ACT_IRQ = 1;
    localparam int unsigned CB_PRE_LO  = 2;
    localparam int unsigned CB_PRE_HI  = 3;
    localparam int unsigned CB_WD      = 5;
    localparam int unsigned CB_EN      = 7;

    // Prescaler selection
    typedef enum logic [1:0] {
        PRE_DIV1   = 2'b00,
        PRE_DIV16  = 2'b01,
        PRE_DIV256 = 2'b10,
        PRE_ALT256 = 2'b11
    } pre_e;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int unsigned DIV_MID_LOG2 = 4,
    parameter int unsigned DIV_HI_LOG2  = 8
) (
    input  logic       clk_i,
    input  logic       por_n_i,
    input  logic       restart_i,
    input  logic       tick_i,
    input  logic [1:0] sel_i,
    output logic       step_o
);
    import wdt_pkg::*;

    localparam int unsigned PRE_W = DIV_HI_LOG2;
    localparam logic [PRE_W-1:0] LIM_MID = PRE_W'((1 << DIV_MID_LOG2) - 1);
    localparam logic [PRE_W-1:0] LIM_HI  = PRE_W'((1 << DIV_HI_LOG2) - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pcnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        unique case (pre_e'(sel_i))
            PRE_DIV1:  lim = '0;
            PRE_DIV16: lim = LIM_MID;
            default:   lim = LIM_HI;
        endcase
        st_d   = st_q;
        step_o = tick_i && (st_q.pcnt >= lim);
        if (restart_i) begin
            st_d.pcnt = '0;
        end else if (tick_i) begin
            st_d.pcnt = step_o ? '0 : st_q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    // R2: the divider phase never passes the selected limit by more than one tick
    p_phase_bound_r2: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (tick_i && !restart_i && step_o) |=> (st_q.pcnt == '0));

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs #(
    parameter int unsigned     DATA_W   = 16,
    parameter logic [DATA_W-1:0] LOAD_RST = 16'h03D7
) (
    input  logic              clk_i,
    input  logic              por_n_i,
    input  logic              soft_rst_i,
    input  logic              wr_load_i,
    input  logic              wr_ctrl_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] load_o,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              locked_o
);
    import wdt_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] load;
        logic [DATA_W-1:0] ctrl;
    } reg_state_t;

    reg_state_t st_d, st_q;

    assign load_o   = st_q.load;
    assign ctrl_o   = st_q.ctrl;
    assign locked_o = st_q.ctrl[CB_WD];

    always_comb begin
        st_d = st_q;
        if (!locked_o) begin
            if (soft_rst_i) begin
                st_d.load = LOAD_RST;
                st_d.ctrl = '0;
            end else begin
                if (wr_load_i) st_d.load = wdata_i;
                if (wr_ctrl_i) st_d.ctrl = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            st_q.load <= LOAD_RST;
            st_q.ctrl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: a locked register set never changes before the next power-on reset
    p_lock_hold_r7: assert property (@(posedge clk_i) disable iff (!por_n_i)
        locked_o |=> ($stable(load_o) && $stable(ctrl_o) && locked_o));

    // R8: a system reset while unlocked restores the defaults
    p_soft_defaults_r8: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (soft_rst_i && !locked_o) |=> (load_o == LOAD_RST && ctrl_o == '0));

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int unsigned       DATA_W  = 16,
    parameter logic [DATA_W-1:0] VAL_RST = 16'h03D7
) (
    input  logic              clk_i,
    input  logic              por_n_i,
    input  logic              soft_rst_i,
    input  logic              reload_i,
    input  logic              step_i,
    input  logic [DATA_W-1:0] load_i,
    input  logic              wd_mode_i,
    input  logic              act_irq_i,
    output logic [DATA_W-1:0] value_o,
    output logic              irq_o,
    output logic              rst_req_o
);

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              irq;
        logic              rst_req;
    } core_state_t;

    core_state_t st_d, st_q;

    assign value_o   = st_q.value;
    assign irq_o     = st_q.irq;
    assign rst_req_o = st_q.rst_req;

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        if (soft_rst_i) begin
            st_d.value = VAL_RST;
            st_d.irq   = 1'b0;
        end else if (reload_i) begin
            st_d.value = load_i;
            st_d.irq   = 1'b0;
        end else if (step_i) begin
            if (st_q.value == '0) begin
                st_d.value = load_i;
                if (wd_mode_i && !act_irq_i) st_d.rst_req = 1'b1;
                else                         st_d.irq     = 1'b1;
            end else begin
                st_d.value = st_q.value - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            st_q.value   <= VAL_RST;
            st_q.irq     <= 1'b0;
            st_q.rst_req <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a step at zero reloads from the load register
    p_zero_reload_r3: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (step_i && !reload_i && !soft_rst_i && value_o == '0) |=> (value_o == $past(load_i)));

    // R3: a step above zero lowers the count by exactly one
    p_dec_one_r3: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (step_i && !reload_i && !soft_rst_i && value_o != '0) |=> (value_o == $past(value_o) - 1'b1));

    // R4: a clear write loads the count and drops the interrupt
    p_clear_reload_r4: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (reload_i && !soft_rst_i) |=> (value_o == $past(load_i) && !irq_o));

    // R5: the interrupt is sticky until cleared
    p_irq_sticky_r5: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (irq_o && !reload_i && !soft_rst_i) |=> irq_o);

    // R6: the reset request lasts one cycle
    p_req_pulse_r6: assert property (@(posedge clk_i) disable iff (!por_n_i)
        rst_req_o |=> !rst_req_o);

    // R9: without a step, clear or reset the count holds
    p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (!step_i && !reload_i && !soft_rst_i) |=> $stable(value_o));

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
    parameter int unsigned       DATA_W       = 16,
    parameter int unsigned       ADDR_W       = 4,
    parameter logic [DATA_W-1:0] LOAD_RST     = 16'h03D7,
    parameter int unsigned       DIV_MID_LOG2 = 4,
    parameter int unsigned       DIV_HI_LOG2  = 8
) (
    input  logic              clk_i,
    input  logic              por_n_i,
    input  logic              sys_rst_n_i,
    input  logic              tick_i,
    input  logic              dbg_halt_i,
    input  logic              pwr_down_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              rst_req_o,
    output logic              irq_o
);
    import wdt_pkg::*;

    localparam int unsigned IDX_LSB = 2;

    logic [DATA_W-1:0] load_q, ctrl_q, value_q;
    logic              locked;
    logic              aligned;
    rsel_e             rsel;
    logic              wr_load, wr_ctrl, wr_clear;
    logic              soft_rst, run, freeze, tick_ok, step;

    assign rsel     = rsel_e'(bus_addr_i[IDX_LSB+1:IDX_LSB]);
    assign aligned  = (bus_addr_i[IDX_LSB-1:0] == '0) && (bus_addr_i >> (IDX_LSB + 2)) == '0;
    assign wr_load  = bus_wr_i && aligned && rsel == RSEL_LOAD;
    assign wr_ctrl  = bus_wr_i && aligned && rsel == RSEL_CTRL;
    assign wr_clear = bus_wr_i && aligned && rsel == RSEL_CLEAR;

    assign soft_rst = !sys_rst_n_i && !locked;
    assign run      = locked || ctrl_q[CB_EN];
    assign freeze   = dbg_halt_i || (pwr_down_i && ctrl_q[CB_PD_STOP]);
    assign tick_ok  = tick_i && run && !freeze;

    wdt_regs #(
        .DATA_W   (DATA_W),
        .LOAD_RST (LOAD_RST)
    ) u_regs (
        .clk_i      (clk_i),
        .por_n_i    (por_n_i),
        .soft_rst_i (soft_rst),
        .wr_load_i  (wr_load),
        .wr_ctrl_i  (wr_ctrl),
        .wdata_i    (bus_wdata_i),
        .load_o     (load_q),
        .ctrl_o     (ctrl_q),
        .locked_o   (locked)
    );

    wdt_prescaler #(
        .DIV_MID_LOG2 (DIV_MID_LOG2),
        .DIV_HI_LOG2  (DIV_HI_LOG2)
    ) u_pre (
        .clk_i     (clk_i),
        .por_n_i   (por_n_i),
        .restart_i (wr_clear || soft_rst),
        .tick_i    (tick_ok),
        .sel_i     (ctrl_q[CB_PRE_HI:CB_PRE_LO]),
        .step_o    (step)
    );

    wdt_core #(
        .DATA_W  (DATA_W),
        .VAL_RST (LOAD_RST)
    ) u_core (
        .clk_i      (clk_i),
        .por_n_i    (por_n_i),
        .soft_rst_i (soft_rst),
        .reload_i   (wr_clear),
        .step_i     (step),
        .load_i     (load_q),
        .wd_mode_i  (locked),
        .act_irq_i  (ctrl_q[CB_ACT_IRQ]),
        .value_o    (value_q),
        .irq_o      (irq_o),
        .rst_req_o  (rst_req_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (aligned) begin
            unique case (rsel)
                RSEL_LOAD:  bus_rdata_o = load_q;
                RSEL_VALUE: bus_rdata_o = value_q;
                RSEL_CTRL:  bus_rdata_o = ctrl_q;
                default:    bus_rdata_o = '0;
            endcase
        end
    end

    // R9: debug halt freezes the count unless a clear or reset intervenes
    p_halt_freeze_r9: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (dbg_halt_i && !wr_clear && !soft_rst) |=> $stable(value_q));

    // R6: a reset request only ever comes out of watchdog mode
    p_req_in_wd_r6: assert property (@(posedge clk_i) disable iff (!por_n_i)
        rst_req_o |-> locked);

    // R8: a system reset in watchdog mode leaves the count alone
    p_sysrst_ignored_r8: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (locked && !sys_rst_n_i && !tick_i && !wr_clear) |=> $stable(value_q));

endmodule

// File: tb/wdt_timer_tb.sv
module wdt_timer_tb;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        tick = 1'b0;
    logic        halt = 1'b0;
    logic        pd = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rst_req;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdt_timer u_dut (
        .clk_i       (clk),
        .por_n_i     (por_n),
        .sys_rst_n_i (sys_rst_n),
        .tick_i      (tick),
        .dbg_halt_i  (halt),
        .pwr_down_i  (pd),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .rst_req_o   (rst_req),
        .irq_o       (irq)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [15:0] load;
        logic [15:0] nticks;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 16'd10, 16'd4},
        '{2'd0, 16'd5,  16'd7},
        '{2'd1, 16'd3,  16'd40},
        '{2'd1, 16'd2,  16'd50},
        '{2'd2, 16'd4,  16'd600},
        '{2'd3, 16'd1,  16'd520}
    };

    function automatic int div_of(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 16 : 256;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_por();
        @(negedge clk); por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); addr = a;
        #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic sys_pulse();
        @(negedge clk); sys_rst_n = 1'b0;
        @(negedge clk); sys_rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        int steps;
        int ld;

        // R1: reset state
        do_por();
        bus_read(4'h0, v); chk("R1 load", v, 16'h03D7);
        bus_read(4'h4, v); chk("R1 value", v, 16'h03D7);
        bus_read(4'h8, v); chk("R1 ctrl", v, 16'h0000);
        bus_read(4'hC, v); chk("R1 clear", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 rst_req", {15'd0, rst_req}, 16'd0);

        // R11: value register is read-only
        bus_write(4'h4, 16'h1234);
        bus_read(4'h4, v); chk("R11 value write ignored", v, 16'h03D7);

        // R2 R3 R5: table of prescaler and period cases
        for (int k = 0; k < NV; k++) begin
            do_por();
            bus_write(4'h0, VEC[k].load);
            bus_write(4'h8, 16'h0080 | (16'(VEC[k].sel) << 2));
            bus_write(4'hC, 16'h0);
            ticks(int'(VEC[k].nticks));
            ld = int'(VEC[k].load);
            steps = int'(VEC[k].nticks) / div_of(VEC[k].sel);
            bus_read(4'h4, v);
            chk("R2 R3 table value", v, 16'(ld - (steps % (ld + 1))));
            chk("R5 table irq", {15'd0, irq}, (steps > ld) ? 16'd1 : 16'd0);
        end

        // R4: clear write reloads and clears the interrupt
        do_por();
        bus_write(4'h0, 16'd10);
        bus_write(4'h8, 16'h0080);
        bus_write(4'hC, 16'h0);
        ticks(3);
        bus_read(4'h4, v); chk("R4 before clear", v, 16'd7);
        bus_write(4'hC, 16'h5A);
        bus_read(4'h4, v); chk("R4 after clear", v, 16'd10);
        ticks(11);
        chk("R5 irq raised", {15'd0, irq}, 16'd1);
        ticks(2);
        chk("R5 irq sticky", {15'd0, irq}, 16'd1);
        bus_write(4'hC, 16'h0);
        chk("R4 irq cleared", {15'd0, irq}, 16'd0);

        // R3: load of zero times out on every step
        bus_write(4'h0, 16'd0);
        bus_write(4'hC, 16'h0);
        ticks(1);
        chk("R3 zero load irq", {15'd0, irq}, 16'd1);
        bus_read(4'h4, v); chk("R3 zero load value", v, 16'd0);

        // R5: disabled timer holds
        do_por();
        bus_write(4'h0, 16'd10);
        bus_write(4'hC, 16'h0);
        ticks(4);
        bus_read(4'h4, v); chk("R5 disabled holds", v, 16'd10);

        // R9: debug halt
        bus_write(4'h8, 16'h0080);
        halt = 1'b1;
        ticks(5);
        bus_read(4'h4, v); chk("R9 halted", v, 16'd10);
        halt = 1'b0;
        ticks(1);
        bus_read(4'h4, v); chk("R9 resumed", v, 16'd9);

        // R10: power-down stop bit
        do_por();
        bus_write(4'h0, 16'd10);
        bus_write(4'h8, 16'h0081);
        bus_write(4'hC, 16'h0);
        pd = 1'b1;
        ticks(3);
        bus_read(4'h4, v); chk("R10 stopped in power-down", v, 16'd10);
        pd = 1'b0;
        ticks(2);
        bus_read(4'h4, v); chk("R10 runs when awake", v, 16'd8);
        do_por();
        bus_write(4'h0, 16'd10);
        bus_write(4'h8, 16'h0080);
        bus_write(4'hC, 16'h0);
        pd = 1'b1;
        ticks(3);
        pd = 1'b0;
        bus_read(4'h4, v); chk("R10 default keeps running", v, 16'd7);

        // R8: system reset in normal mode restores defaults
        bus_write(4'h0, 16'h0020);
        sys_pulse();
        bus_read(4'h0, v); chk("R8 normal load", v, 16'h03D7);
        bus_read(4'h8, v); chk("R8 normal ctrl", v, 16'h0000);
        bus_read(4'h4, v); chk("R8 normal value", v, 16'h03D7);

        // R6: watchdog timeout gives a one-cycle reset request
        do_por();
        bus_write(4'h0, 16'd3);
        bus_write(4'h8, 16'h0020);
        bus_write(4'hC, 16'h0);
        ticks(3);
        bus_read(4'h4, v); chk("R6 at zero", v, 16'd0);
        chk("R6 no request yet", {15'd0, rst_req}, 16'd0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk("R6 request high", {15'd0, rst_req}, 16'd1);
        @(negedge clk);
        chk("R6 request one cycle", {15'd0, rst_req}, 16'd0);
        chk("R6 no irq on reset action", {15'd0, irq}, 16'd0);
        bus_read(4'h4, v); chk("R6 reloaded", v, 16'd3);

        // R7: lock
        bus_write(4'h0, 16'h0055);
        bus_read(4'h0, v); chk("R7 load locked", v, 16'd3);
        bus_write(4'h8, 16'h0000);
        bus_read(4'h8, v); chk("R7 ctrl locked", v, 16'h0020);
        ticks(1);
        bus_read(4'h4, v); chk("R7 still counting", v, 16'd2);

        // R8: system reset in watchdog mode has no effect
        sys_pulse();
        bus_read(4'h4, v); chk("R8 wd value kept", v, 16'd2);
        bus_read(4'h8, v); chk("R8 wd ctrl kept", v, 16'h0020);
        bus_read(4'h0, v); chk("R8 wd load kept", v, 16'd3);
        bus_write(4'hC, 16'h0);
        bus_read(4'h4, v); chk("R7 clear still works", v, 16'd3);

        // R6: interrupt action
        do_por();
        bus_write(4'h0, 16'd2);
        bus_write(4'h8, 16'h0022);
        bus_write(4'hC, 16'h0);
        ticks(3);
        chk("R6 irq action", {15'd0, irq}, 16'd1);
        chk("R6 irq action no request", {15'd0, rst_req}, 16'd0);
        bus_read(4'h4, v); chk("R6 irq action reload", v, 16'd2);
        bus_write(4'hC, 16'h0);
        chk("R6 irq cleared", {15'd0, irq}, 16'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule